// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens passively to the two wires of an I2C bus and tells a multi-master controller whether it may claim the bus. Both wires are first brought into the system clock domain through a chain of flip-flops. The block then compares each new sample with the one before it to find START conditions (data falling while the clock is high) and STOP conditions (data rising while the clock is high).

Two sticky flags record which of the two conditions came last. A bus-free output is derived from them. The bus counts as free after a STOP, and also in the idle state after reset or disable, when neither flag is set. An optional single-cycle interrupt pulse marks every detected condition. A controller can therefore wait for the end of another master's transfer without polling.

The block never drives the bus. It does not decode addresses and it does not handle data bytes.

Top module: `i2c_cond_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `start_seen` and `stop_seen` are 0, `irq` is 0 and `bus_free` is 1.
- R2: A START sets `start_seen` to 1, clears `stop_seen` and drives `bus_free` to 0. A START is a synchronised SDA sample going from 1 to 0 while the SCL sample is 1 both before and after.
- R3: A STOP sets `stop_seen` to 1, clears `start_seen` and drives `bus_free` to 1. A STOP is a synchronised SDA sample going from 0 to 1 while the SCL sample is 1 both before and after.
- R4: A change on SDA while SCL is 0 leaves both flags unchanged and raises no `irq`.
- R5: If SDA and SCL change in the same synchronised sample, no condition is detected, because SCL was not high on both sides of the SDA change.
- R6: While `en` is 0, both flags are 0, `bus_free` is 1 and `irq` stays 0. If a condition is detected on the same clock edge at which `en` is sampled 0, the disable wins and the flags still read 0. Re-enabling the block does not produce a condition from the bus history.
- R7: Each detected condition produces `irq` high for exactly one cycle when `irq_en` is 1, and no pulse when `irq_en` is 0. The flags update in both cases.
- R8: With the default of 2 synchroniser stages, the flags and `irq` change on the third rising clock edge after a wire changes. They are unchanged after the second edge.
- R9: A repeated START while `start_seen` is already 1 keeps `start_seen` at 1 and raises a new `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; when 0, the flags are held clear |
| irq_en | input | 1 | Interrupt enable |
| sda_in | input | 1 | I2C data wire as seen at the pad |
| scl_in | input | 1 | I2C clock wire as seen at the pad |
| start_seen | output | 1 | Sticky: the most recent condition was a START |
| stop_seen | output | 1 | Sticky: the most recent condition was a STOP |
| bus_free | output | 1 | The bus may be claimed |
| irq | output | 1 | Single-cycle pulse on each detected condition |

## Verification
Two things can land on the same clock edge: a condition being detected and the block being disabled. The bench provokes this by making an SDA fall while SCL is high, counting the two synchroniser edges, and lowering `en` just before the edge on which the START would be registered. On that edge the flags must read clear and no interrupt may appear, and re-enabling must not bring back a stale START. A second coincidence is SDA and SCL toggling in the same sample. The bench drives both wires on one edge and checks that neither flag moves and no interrupt appears.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int SYNC_DEPTH_DEFAULT = 2;
    localparam int LINE_COUNT         = 2;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_t;

    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_START = 2'd1,
        COND_STOP  = 2'd2
    } cond_e;

    localparam line_t LINE_IDLE = '{sda: 1'b1, scl: 1'b1};

    function automatic cond_e classify(input line_t prev, input line_t cur);
        cond_e res;
        res = COND_NONE;
        if (prev.scl && cur.scl) begin
            if (prev.sda && !cur.sda)
                res = COND_START;
            else if (!prev.sda && cur.sda)
                res = COND_STOP;
        end
        return res;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    genvar w;
    generate
        for (w = 0; w < WIDTH; w++) begin : g_bit
            logic [STAGES-1:0] chain;
            if (STAGES == 1) begin : g_single
                always_ff @(posedge clk) begin
                    if (rst) chain <= 1'b1;
                    else     chain <= d[w];
                end
            end else begin : g_multi
                always_ff @(posedge clk) begin
                    if (rst) chain <= '1;
                    else     chain <= {chain[STAGES-2:0], d[w]};
                end
            end
            assign q[w] = chain[LAST];
        end
    endgenerate
endmodule

// File: rtl/i2cmon_edge.sv
module i2cmon_edge
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t cur,
    output cond_e cond
);
    line_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= LINE_IDLE;
        else     prev <= cur;
    end

    assign cond = classify(prev, cur);
endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  irq_en,
    input  cond_e cond,
    output logic  start_seen,
    output logic  stop_seen,
    output logic  bus_free,
    output logic  irq
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else begin
            unique case (cond)
                COND_START: begin
                    start_seen <= 1'b1;
                    stop_seen  <= 1'b0;
                end
                COND_STOP: begin
                    start_seen <= 1'b0;
                    stop_seen  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= en && irq_en && (cond != COND_NONE);
    end

    assign bus_free = stop_seen || (!start_seen && !stop_seen);
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic irq_en,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq
);
    line_t raw;
    line_t synced;
    cond_e cond;

    assign raw.sda = sda_in;
    assign raw.scl = scl_in;

    i2cmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_COUNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    i2cmon_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .cur  (synced),
        .cond (cond)
    );

    i2cmon_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .irq_en     (irq_en),
        .cond       (cond),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .bus_free   (bus_free),
        .irq        (irq)
    );
endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk
    import i2cmon_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  en,
    input logic  irq_en,
    input logic  start_seen,
    input logic  stop_seen,
    input logic  bus_free,
    input logic  irq,
    input cond_e cond
);
    // R2 / R3: the two flags never hold together
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen));

    // R2: a START flag only rises after a detected START
    p_start_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(start_seen) |-> ($past(cond) == COND_START));

    // R3: a STOP flag only rises after a detected STOP, and it means free
    p_stop_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_seen) |-> ($past(cond) == COND_STOP));

    p_stop_free_r3: assert property (@(posedge clk) disable iff (rst)
        stop_seen |-> bus_free);

    // R4: with no condition, the flags hold
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (en && cond == COND_NONE) |=> ($stable(start_seen) && $stable(stop_seen)));

    // R6: disable clears the flags and silences the interrupt
    p_disable_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!start_seen && !stop_seen && !irq));

    // R7: an interrupt requires the enable on the previous cycle
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(cond) != COND_NONE));
endmodule

bind i2c_cond_monitor i2cmon_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .irq_en     (irq_en),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_free   (bus_free),
    .irq        (irq),
    .cond       (cond)
);

// File: tb/sim_i2c_cond_monitor.sv
`timescale 1ns/1ps
module sim_i2c_cond_monitor;
    logic clk = 1'b0;
    logic rst, en, irq_en, sda, scl;
    logic start_seen, stop_seen, bus_free, irq;
    int   checks = 0;
    int   errors = 0;
    int   irq_cnt = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    i2c_cond_monitor u0 (
        .clk(clk), .rst(rst), .en(en), .irq_en(irq_en),
        .sda_in(sda), .scl_in(scl),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .bus_free(bus_free), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drive(input logic d, input logic c);
        sda = d;
        scl = c;
        settle();
    endtask

    task automatic flags_are(input string req, input int s, input int p, input int f);
        check(req, "start_seen", int'(start_seen), s);
        check(req, "stop_seen", int'(stop_seen), p);
        check(req, "bus_free", int'(bus_free), f);
    endtask

    task automatic t_reset();
        rst = 1; en = 1; irq_en = 1; sda = 1; scl = 1;
        repeat (3) @(negedge clk);
        flags_are("R1", 0, 0, 1);
        check("R1", "irq in reset", int'(irq), 0);
        rst = 0;
        @(negedge clk);
        flags_are("R1", 0, 0, 1);
        check("R1", "irq after reset", int'(irq), 0);
    endtask

    task automatic t_latency_start();
        int base = irq_cnt;
        sda = 0;
        @(negedge clk);
        @(negedge clk);
        check("R8", "start after 2 edges", int'(start_seen), 0);
        @(negedge clk);
        check("R8", "start after 3 edges", int'(start_seen), 1);
        check("R8", "irq on 3rd edge", int'(irq), 1);
        @(negedge clk);
        check("R7", "irq width one cycle", int'(irq), 0);
        settle();
        flags_are("R2", 1, 0, 0);
        check("R7", "one pulse for START", irq_cnt - base, 1);
    endtask

    task automatic t_stop();
        int base = irq_cnt;
        drive(0, 0);
        drive(0, 1);
        check("R4", "no irq SCL low moves", irq_cnt - base, 0);
        flags_are("R4", 1, 0, 0);
        drive(1, 1);
        flags_are("R3", 0, 1, 1);
        check("R3", "irq for STOP", irq_cnt - base, 1);
    endtask

    task automatic t_scl_low();
        int base = irq_cnt;
        drive(1, 0);
        drive(0, 0);
        drive(1, 0);
        drive(1, 1);
        flags_are("R4", 0, 1, 1);
        check("R4", "no irq", irq_cnt - base, 0);
    endtask

    task automatic t_simultaneous();
        int base = irq_cnt;
        drive(0, 0);
        flags_are("R5", 0, 1, 1);
        drive(1, 1);
        flags_are("R5", 0, 1, 1);
        check("R5", "no irq joint change", irq_cnt - base, 0);
    endtask

    task automatic t_repeat_start();
        int base = irq_cnt;
        drive(0, 1);
        flags_are("R2", 1, 0, 0);
        drive(0, 0);
        drive(1, 0);
        drive(1, 1);
        drive(0, 1);
        flags_are("R9", 1, 0, 0);
        check("R9", "two START pulses", irq_cnt - base, 2);
        drive(0, 0);
        drive(0, 1);
        drive(1, 1);
        flags_are("R3", 0, 1, 1);
    endtask

    task automatic t_irq_gate();
        int base = irq_cnt;
        irq_en = 0;
        drive(0, 1);
        flags_are("R7", 1, 0, 0);
        drive(1, 1);
        flags_are("R7", 0, 1, 1);
        check("R7", "no irq when gated", irq_cnt - base, 0);
        irq_en = 1;
        settle();
    endtask

    task automatic t_disable_collide();
        int base = irq_cnt;
        sda = 0;
        @(negedge clk);
        @(negedge clk);
        en = 0;
        @(negedge clk);
        flags_are("R6", 0, 0, 1);
        check("R6", "irq on collision", int'(irq), 0);
        settle();
        flags_are("R6", 0, 0, 1);
        drive(0, 0);
        drive(1, 0);
        drive(1, 1);
        drive(0, 1);
        flags_are("R6", 0, 0, 1);
        check("R6", "no irq while disabled", irq_cnt - base, 0);
        en = 1;
        settle();
        flags_are("R6", 0, 0, 1);
        check("R6", "no stale irq on enable", irq_cnt - base, 0);
        drive(1, 1);
        flags_are("R3", 0, 1, 1);
    endtask

    initial begin
        t_reset();
        t_latency_start();
        t_stop();
        t_scl_low();
        t_simultaneous();
        t_repeat_start();
        t_irq_gate();
        t_disable_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule